// File: doc/BRIEF.md
# Saturating Trim Code Register with Nonvolatile Store and Recall

The block keeps an 8-bit trim setting that drives the code input of a 256-step output DAC. A strobe decoder in front of it supplies level-sensitive increment and decrement strobes and a program strobe. The block steps the setting by one per enabled cycle and clamps it at both ends of the range. The adjustment path is live only while `adj_en` is high. Each time the enable rises, counting is held off for a settling window, and the first strobe after that window is swallowed. The strobe that follows a program operation is swallowed in the same way.

The block moves data between the working register and a one-byte nonvolatile cell over a request/done handshake. The cell sits outside the block and has its own write and read latencies. After reset the block fetches the stored byte on its own. A falling edge of `adj_en` fetches it again and throws away any changes that were not stored. A program strobe writes the current setting to the cell. `busy` is high for the whole of a store or a fetch. While `busy` is high, every strobe is dropped.

Top module: `trim_code_keeper`

## Requirements
- R1: With `adj_en` high for more than one cycle, the settling window over, no transfer running, and the one-strobe discard already used, each cycle with `inc_stb` high alone raises `dac_code` by 1 after the next edge. Each cycle with `dec_stb` high alone lowers it by 1. A cycle with both strobes high leaves it unchanged.
- R2: `dac_code` stays at 255 when incremented at 255 and stays at 0 when decremented at 0. It never wraps.
- R3: After `adj_en` rises, the first count strobe accepted after the settling window leaves `dac_code` unchanged. Counting resumes from the next strobe.
- R4: After a store completes, the next count strobe is discarded in the same way.
- R5: A `prog_stb` with `adj_en` high and no transfer running raises `nv_req` with `nv_wr`=1 and `nv_wdata` equal to `dac_code`. `busy`, `nv_req`, `nv_wr` and `nv_wdata` then hold until the cycle after `nv_done`. `dac_code` is not changed by a store.
- R6: After reset, the block issues a read (`nv_req`=1, `nv_wr`=0). When `nv_done` arrives, it loads `nv_rdata` into `dac_code` and drops `busy`.
- R7: A falling edge of `adj_en` while idle starts a read. The stored byte replaces `dac_code`, including any unstored adjustments.
- R8: While reset is held and until the first read completes, `dac_code` reads 0x80 (mid-scale) and `busy` is 1.
- R9: Strobes that arrive within `ARM_CYC` cycles after `adj_en` rises are ignored. They do not use up the discard of R3.
- R10: Count and program strobes have no effect while `busy` is high or while `adj_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the working register and sequencer |
| adj_en | input | 1 | Adjustment enable; its falling edge triggers a reload |
| inc_stb | input | 1 | Count-up strobe, one step per cycle high |
| dec_stb | input | 1 | Count-down strobe, one step per cycle high |
| prog_stb | input | 1 | Request to store the current setting |
| nv_req | output | 1 | Storage request, held until done |
| nv_wr | output | 1 | 1 = write, 0 = read, valid with nv_req |
| nv_wdata | output | W | Byte to be written |
| nv_done | input | 1 | One-cycle completion pulse from storage |
| nv_rdata | input | W | Stored byte, valid with nv_done |
| dac_code | output | W | Trim code to the DAC |
| busy | output | 1 | A store or a fetch is in progress |

## Verification
A count strobe that is high across one rising edge shows up on `dac_code` right after that edge. The register is the only stage on the path. The bench drives every input on a falling edge and reads the result on the next falling edge. A program strobe shows `busy`, `nv_req` and `nv_wr` on that same next falling edge. The result of a fetch appears on the falling edge after the storage model's done pulse, so fetch results are read only once `busy` has dropped. For the settling window, the bench waits `ARM_CYC`+2 falling edges after raising the enable, which covers the edge-detect register plus the full count-down.

// File: rtl/trim_code_keeper.sv
module trim_code_keeper #(
  parameter int W = 8,
  parameter int ARM_CYC = 6250,
  parameter logic [W-1:0] RST_CODE = 8'h80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adj_en,
  input  logic         inc_stb,
  input  logic         dec_stb,
  input  logic         prog_stb,
  output logic         nv_req,
  output logic         nv_wr,
  output logic [W-1:0] nv_wdata,
  input  logic         nv_done,
  input  logic [W-1:0] nv_rdata,
  output logic [W-1:0] dac_code,
  output logic         busy
);
  localparam int AW = $clog2(ARM_CYC + 2);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_STORE} st_t;
  st_t st;
  logic en_q, skip;
  logic [AW-1:0] arm;

  wire rise  = adj_en & ~en_q;
  wire fall  = ~adj_en & en_q;
  wire armed = adj_en && en_q && (arm == '0);
  wire up    = armed && inc_stb && !dec_stb && !prog_stb;
  wire dn    = armed && dec_stb && !inc_stb && !prog_stb;

  assign busy     = (st != ST_IDLE);
  assign nv_req   = busy;
  assign nv_wr    = (st == ST_STORE);
  assign nv_wdata = dac_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_LOAD;
      dac_code <= RST_CODE;
      en_q     <= 1'b0;
      skip     <= 1'b1;
      arm      <= '0;
    end else begin
      en_q <= adj_en;
      if (rise) begin
        skip <= 1'b1;
        arm  <= AW'(ARM_CYC);
      end else if (arm != '0) begin
        arm <= arm - 1'b1;
      end
      case (st)
        ST_LOAD: if (nv_done) begin
          dac_code <= nv_rdata;
          st       <= ST_IDLE;
        end
        ST_STORE: if (nv_done) begin
          skip <= 1'b1;
          st   <= ST_IDLE;
        end
        default: begin
          if (fall) st <= ST_LOAD;
          else if (adj_en && en_q && prog_stb) st <= ST_STORE;
          else if (up || dn) begin
            if (skip) skip <= 1'b0;
            else if (up && dac_code != TOP) dac_code <= dac_code + W'(1);
            else if (dn && dac_code != '0) dac_code <= dac_code - W'(1);
          end
        end
      endcase
    end
  end
endmodule

module trim_code_keeper_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic         adj_en,
  input logic         nv_req,
  input logic         nv_wr,
  input logic [W-1:0] nv_wdata,
  input logic         nv_done,
  input logic [W-1:0] dac_code,
  input logic         busy
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_done |=> (dac_code == $past(dac_code) || dac_code == $past(dac_code) + W'(1) || dac_code == $past(dac_code) - W'(1))); // R1
  AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code == TOP && !nv_done) |=> dac_code != '0); // R2
  AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code == '0 && !nv_done) |=> dac_code != TOP); // R2
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !nv_done) |=> $stable(dac_code)); // R10
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adj_en && !busy) |=> $stable(dac_code)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req && !nv_done) |=> (nv_req && $stable(nv_wr))); // R5
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req && nv_wr && !nv_done) |=> $stable(nv_wdata)); // R5
endmodule

bind trim_code_keeper trim_code_keeper_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adj_en(adj_en), .nv_req(nv_req), .nv_wr(nv_wr),
  .nv_wdata(nv_wdata), .nv_done(nv_done), .dac_code(dac_code), .busy(busy)
);

// File: tb/tb_trim_code_keeper.sv
module tb_trim_code_keeper;
  localparam int W = 8;
  localparam int ARM = 4;
  localparam int WR_LAT = 20;
  localparam int RD_LAT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adj_en = 1'b0, inc_stb = 1'b0, dec_stb = 1'b0, prog_stb = 1'b0;
  logic nv_req, nv_wr, busy;
  logic [W-1:0] nv_wdata, dac_code;
  logic nv_done = 1'b0;
  logic [W-1:0] nv_rdata = '0;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  trim_code_keeper #(.W(W), .ARM_CYC(ARM)) dut (
    .clk(clk), .rst_n(rst_n), .adj_en(adj_en), .inc_stb(inc_stb), .dec_stb(dec_stb),
    .prog_stb(prog_stb), .nv_req(nv_req), .nv_wr(nv_wr), .nv_wdata(nv_wdata),
    .nv_done(nv_done), .nv_rdata(nv_rdata), .dac_code(dac_code), .busy(busy)
  );

  // Nonvolatile cell model: survives reset of the block.
  logic [W-1:0] mem = 8'h80;
  logic act = 1'b0, op_wr = 1'b0;
  logic [W-1:0] op_data = '0;
  int cnt = 0;
  always @(posedge clk) begin
    nv_done <= 1'b0;
    if (act) begin
      if (cnt <= 1) begin
        act <= 1'b0;
        nv_done <= 1'b1;
        if (op_wr) mem <= op_data;
        nv_rdata <= op_wr ? op_data : mem;
      end else cnt <= cnt - 1;
    end else if (nv_req && !nv_done) begin
      act <= 1'b1;
      op_wr <= nv_wr;
      op_data <= nv_wdata;
      cnt <= nv_wr ? WR_LAT : RD_LAT;
    end
  end

  task automatic check(input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act_v, exp_v);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_inc(input int n);
    inc_stb = 1'b1; step(n); inc_stb = 1'b0;
  endtask

  task automatic hold_dec(input int n);
    dec_stb = 1'b1; step(n); dec_stb = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    step(3);
    check("R8 code in reset", dac_code, 8'h80);
    check("R8 busy in reset", busy, 1);
    rst_n = 1'b1;
    step(1);
    check("R6 read request", {nv_req, nv_wr}, 2'b10);
    check("R8 code before load", dac_code, 8'h80);
    wait_idle();
    check("R6 loaded byte", dac_code, 8'h80);
  endtask

  task automatic t_first_skip();
    adj_en = 1'b1; step(ARM + 2);
    hold_inc(1);
    check("R3 first strobe dropped", dac_code, 8'h80);
    hold_inc(1);
    check("R1 increment", dac_code, 8'h81);
    hold_dec(2);
    check("R1 decrement", dac_code, 8'h7F);
    inc_stb = 1'b1; dec_stb = 1'b1; step(1); inc_stb = 1'b0; dec_stb = 1'b0;
    check("R1 both strobes", dac_code, 8'h7F);
  endtask

  task automatic t_arm();
    adj_en = 1'b0; step(1); wait_idle();
    check("R7 reload discards edits", dac_code, 8'h80);
    hold_inc(3);
    check("R10 strobe while disabled", dac_code, 8'h80);
    adj_en = 1'b1; step(1);
    hold_inc(2);
    check("R9 strobe in settling window", dac_code, 8'h80);
    step(ARM + 2);
    hold_inc(1);
    check("R3 discard kept after window", dac_code, 8'h80);
    hold_inc(1);
    check("R9 counting after window", dac_code, 8'h81);
  endtask

  task automatic t_saturate();
    hold_inc(140);
    check("R2 top clamp", dac_code, 8'hFF);
    hold_inc(3);
    check("R2 no wrap up", dac_code, 8'hFF);
    hold_dec(300);
    check("R2 bottom clamp", dac_code, 8'h00);
  endtask

  task automatic t_program();
    hold_inc(8'h5A);
    check("R1 ramp", dac_code, 8'h5A);
    prog_stb = 1'b1; step(1); prog_stb = 1'b0;
    check("R5 busy on store", busy, 1);
    check("R5 write request", {nv_req, nv_wr}, 2'b11);
    check("R5 write data", nv_wdata, 8'h5A);
    hold_inc(3);
    prog_stb = 1'b1; step(1); prog_stb = 1'b0;
    wait_idle();
    check("R10 strobes during store", dac_code, 8'h5A);
    step(1);
    check("R10 prog during store", busy, 0);
    hold_inc(1);
    check("R4 strobe after store dropped", dac_code, 8'h5A);
    hold_inc(1);
    check("R4 counting resumes", dac_code, 8'h5B);
  endtask

  task automatic t_reload();
    adj_en = 1'b0; step(1);
    check("R7 reload busy", {busy, nv_wr}, 2'b10);
    hold_dec(4);
    wait_idle();
    check("R7 stored byte recalled", dac_code, 8'h5A);
  endtask

  task automatic t_powerup();
    adj_en = 1'b1; step(ARM + 2);
    hold_inc(5);
    rst_n = 1'b0; step(2);
    check("R8 code after reset", dac_code, 8'h80);
    rst_n = 1'b1; step(1); wait_idle();
    check("R6 power-up recall", dac_code, 8'h5A);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 200000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_skip();
    t_arm();
    t_saturate();
    t_program();
    t_reload();
    t_powerup();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule